// File: doc/BRIEF.md
# USB PD BMC packet receiver

This block takes the sampled level of a Type-C configuration-channel line and recovers Power Delivery packets from it. The line is synchronised and edge-detected, and the time between transitions is measured. The line counts as active while transitions keep arriving. It counts as static once a programmable number of half-bit periods pass with no transition.

The block locks to the alternating preamble. It averages a fixed number of preamble bits to find the bit period, and then splits each following interval into a long one (a zero) or a pair of short ones (a one). The decoded bits are searched for the start-of-packet ordered set. A partial match is accepted when only one of its four K-codes is damaged.

After that match the bits are grouped into 5-bit symbols and translated to nibbles. The nibbles are paired into bytes and handed to a consumer over a valid/ready byte stream. The end-of-packet symbol closes the message and triggers a CRC-32 check. A byte count and sticky status flags then tell the consumer how the message ended.

Top module: `pd_bmc_rx`

## Requirements
- R1: After reset, `rx_valid`, `ord_det`, `msg_end`, `rx_err`, `rx_ovr` are 0 and `pay_size` is 0.
- R2: The line uses biphase mark coding. Every bit starts with a transition, and a one has an extra transition in mid-bit. A preamble of alternating bits starting with 0 comes first. The first 2^AVG_LOG2 preamble bits set the bit time. After that, an interval of at least three quarters of the bit time is a zero and two short intervals are a one.
- R3: Symbols travel least-significant bit first. The start ordered set is the K-codes 5'b11000, 5'b11000, 5'b11000, 5'b10001 in that order. It is accepted when at least three of the four codes match. `ord_det` rises once the set is accepted.
- R4: Data symbols use the 4b5b code. The codes for nibble values 0 to F are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101. The first nibble of a pair is the low nibble. Each byte is presented on `rx_data` with `rx_valid` and is held unchanged until `rx_ready` is high at a clock edge.
- R5: The message closes on the symbol 5'b01101, which sets `msg_end`. The last four bytes are a reflected CRC-32, sent low byte first. The CRC uses polynomial 0x04C11DB7 with initial value all ones and the result inverted. A mismatch sets `rx_err` together with `msg_end`.
- R6: At message end `pay_size` takes the number of bytes decoded in that message, including the four CRC bytes. It keeps that value until the next message ends.
- R7: If the line stays static for (WIN_HBITS_M1+1) half-bit periods after the ordered set and before the end symbol, `msg_end` and `rx_err` are set.
- R8: A 5-bit symbol that is neither a data code nor the end code ends the message with `rx_err` and `msg_end` set.
- R9: If a byte is decoded while `rx_valid` is high and `rx_ready` is low, `rx_ovr` is set. The new byte is dropped and the held byte stays on `rx_data`.
- R10: A one on `clr_ord` clears `ord_det`. A one on `clr_end` clears `msg_end` and `rx_err`. A one on `clr_ovr` clears `rx_ovr`. A new setting event in the same cycle wins.
- R11: `ord_det` returns to 0 in the cycle where `msg_end` is set.
- R12: A start set with two or more damaged K-codes is ignored. `ord_det` and `msg_end` stay 0 and no byte is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cc_line | input | 1 | Sampled CC line level |
| rx_ready | input | 1 | Consumer accepts the presented byte |
| clr_ord | input | 1 | Write-one clear of `ord_det` |
| clr_end | input | 1 | Write-one clear of `msg_end` and `rx_err` |
| clr_ovr | input | 1 | Write-one clear of `rx_ovr` |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | A received byte is waiting (receive not empty) |
| ord_det | output | 1 | Start ordered set accepted, message in progress |
| msg_end | output | 1 | Sticky: a message has ended |
| rx_err | output | 1 | Sticky: CRC mismatch, bad symbol or truncation |
| rx_ovr | output | 1 | Sticky: a byte was lost because the consumer stalled |
| pay_size | output | SIZE_W | Bytes decoded in the last message |

## Verification
A wrong bit-time estimate or threshold mislabels intervals. This shows within one symbol as a corrupted byte, or as a bad-symbol error raised about ten bits after the start set. A bad CRC register state leaves the bytes correct, so it is seen only at the end symbol as a spurious or missing `rx_err`. Symbol or nibble misalignment shows on the very first byte compared, and a wrong count shows in `pay_size` the cycle after the end symbol is decoded. A broken stream hold or overrun path shows on the next byte decoded while the consumer stalls.

// File: rtl/pd_bmc_rx_pkg.sv
package pd_bmc_rx_pkg;

    localparam logic [4:0]  K_SYNC1     = 5'b11000;
    localparam logic [4:0]  K_SYNC2     = 5'b10001;
    localparam logic [4:0]  K_EOP       = 5'b01101;
    localparam logic [31:0] CRC_POLY_RF = 32'hEDB88320;
    localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;

    typedef enum logic [1:0] {RX_HUNT, RX_DATA, RX_DRAIN} rx_state_e;
    typedef enum logic [1:0] {SYM_DATA, SYM_EOP, SYM_BAD} sym_kind_e;

    typedef struct packed {
        sym_kind_e  kind;
        logic [3:0] nib;
    } sym_dec_t;

    function automatic sym_dec_t decode_sym(input logic [4:0] code);
        sym_dec_t d;
        d.kind = SYM_DATA;
        d.nib  = 4'h0;
        case (code)
            5'b11110: d.nib = 4'h0;
            5'b01001: d.nib = 4'h1;
            5'b10100: d.nib = 4'h2;
            5'b10101: d.nib = 4'h3;
            5'b01010: d.nib = 4'h4;
            5'b01011: d.nib = 4'h5;
            5'b01110: d.nib = 4'h6;
            5'b01111: d.nib = 4'h7;
            5'b10010: d.nib = 4'h8;
            5'b10011: d.nib = 4'h9;
            5'b10110: d.nib = 4'hA;
            5'b10111: d.nib = 4'hB;
            5'b11010: d.nib = 4'hC;
            5'b11011: d.nib = 4'hD;
            5'b11100: d.nib = 4'hE;
            5'b11101: d.nib = 4'hF;
            K_EOP:    d.kind = SYM_EOP;
            default:  d.kind = SYM_BAD;
        endcase
        return d;
    endfunction

    function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ b[i]) r = (r >> 1) ^ CRC_POLY_RF;
            else             r = r >> 1;
        end
        return r;
    endfunction

    // Number of K-codes in a 20-bit window (oldest code in the low bits) that match the start set
    function automatic logic [2:0] kcode_hits(input logic [19:0] w);
        logic [2:0] n;
        n = 3'd0;
        if (w[4:0]   == K_SYNC1) n = n + 3'd1;
        if (w[9:5]   == K_SYNC1) n = n + 3'd1;
        if (w[14:10] == K_SYNC1) n = n + 3'd1;
        if (w[19:15] == K_SYNC2) n = n + 3'd1;
        return n;
    endfunction

endpackage

// File: rtl/pd_bmc_edge_timer.sv
module pd_bmc_edge_timer #(
    parameter int CNT_W    = 16,
    parameter int WIN_CLKS = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_in,
    output logic             edge_p,
    output logic [CNT_W-1:0] interval,
    output logic             line_static
);
    logic [1:0]       sync_q;
    logic             last_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
            cnt_q  <= '1;
        end else begin
            sync_q <= {sync_q[0], line_in};
            last_q <= sync_q[1];
            if (edge_p)           cnt_q <= CNT_W'(1);
            else if (cnt_q != '1) cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign edge_p      = sync_q[1] ^ last_q;
    assign interval    = cnt_q;
    assign line_static = (cnt_q >= CNT_W'(WIN_CLKS));
endmodule

// File: rtl/pd_bmc_bit_slicer.sv
module pd_bmc_bit_slicer #(
    parameter int CNT_W    = 16,
    parameter int AVG_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             edge_p,
    input  logic [CNT_W-1:0] interval,
    input  logic             line_static,
    output logic             bit_stb,
    output logic             bit_val
);
    // Alternating preamble: three transitions per two bits
    localparam int TR_GOAL = 3 << (AVG_LOG2 - 1);
    localparam int TRC_W   = $clog2(TR_GOAL + 1);
    localparam int ACC_W   = CNT_W + AVG_LOG2 + 1;

    logic             started_q, locked_q, half_q;
    logic [TRC_W-1:0] ntr_q;
    logic [ACC_W-1:0] acc_q, acc_nxt;
    logic [ACC_W+1:0] acc_x3;
    logic [CNT_W-1:0] thr_q;

    assign acc_nxt = acc_q + ACC_W'(interval);
    assign acc_x3  = {2'b00, acc_nxt} + {1'b0, acc_nxt, 1'b0};

    always_ff @(posedge clk) begin
        if (rst) begin
            started_q <= 1'b0;
            locked_q  <= 1'b0;
            half_q    <= 1'b0;
            ntr_q     <= '0;
            acc_q     <= '0;
            thr_q     <= '0;
            bit_stb   <= 1'b0;
            bit_val   <= 1'b0;
        end else begin
            bit_stb <= 1'b0;
            if (edge_p) begin
                if (!started_q) begin
                    started_q <= 1'b1;
                    ntr_q     <= '0;
                    acc_q     <= '0;
                end else if (!locked_q) begin
                    acc_q <= acc_nxt;
                    if (ntr_q == TRC_W'(TR_GOAL - 1)) begin
                        locked_q <= 1'b1;
                        half_q   <= 1'b0;
                        thr_q    <= CNT_W'(acc_x3 >> (AVG_LOG2 + 2));
                    end else begin
                        ntr_q <= ntr_q + TRC_W'(1);
                    end
                end else if (interval >= thr_q) begin
                    bit_stb <= 1'b1;
                    bit_val <= 1'b0;
                    half_q  <= 1'b0;
                end else if (half_q) begin
                    bit_stb <= 1'b1;
                    bit_val <= 1'b1;
                    half_q  <= 1'b0;
                end else begin
                    half_q <= 1'b1;
                end
            end else if (line_static) begin
                started_q <= 1'b0;
                locked_q  <= 1'b0;
                half_q    <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pd_bmc_rx.sv
module pd_bmc_rx
    import pd_bmc_rx_pkg::*;
#(
    parameter int HBIT_CLKS    = 8,
    parameter int WIN_HBITS_M1 = 7,
    parameter int AVG_LOG2     = 4,
    parameter int CNT_W        = 16,
    parameter int SIZE_W       = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cc_line,
    input  logic              rx_ready,
    input  logic              clr_ord,
    input  logic              clr_end,
    input  logic              clr_ovr,
    output logic [7:0]        rx_data,
    output logic              rx_valid,
    output logic              ord_det,
    output logic              msg_end,
    output logic              rx_err,
    output logic              rx_ovr,
    output logic [SIZE_W-1:0] pay_size
);
    localparam int WIN_CLKS = (WIN_HBITS_M1 + 1) * HBIT_CLKS;

    logic             edge_p, line_static, bit_stb, bit_val;
    logic [CNT_W-1:0] interval;

    pd_bmc_edge_timer #(.CNT_W(CNT_W), .WIN_CLKS(WIN_CLKS)) u_edge (
        .clk(clk), .rst(rst), .line_in(cc_line),
        .edge_p(edge_p), .interval(interval), .line_static(line_static)
    );

    pd_bmc_bit_slicer #(.CNT_W(CNT_W), .AVG_LOG2(AVG_LOG2)) u_slice (
        .clk(clk), .rst(rst), .edge_p(edge_p), .interval(interval),
        .line_static(line_static), .bit_stb(bit_stb), .bit_val(bit_val)
    );

    rx_state_e         state_q;
    logic [18:0]       win_q;
    logic [3:0]        sym_q, lo_nib_q;
    logic [2:0]        bcnt_q;
    logic              nib_half_q;
    logic [31:0]       crc_q;
    logic [SIZE_W-1:0] cnt_q;

    logic [19:0] win_nxt;
    logic [4:0]  sym_full;
    sym_dec_t    dec;
    logic        sop_hit, emit, fin, fin_err;
    logic [7:0]  emit_byte;

    assign win_nxt  = {bit_val, win_q};
    assign sym_full = {bit_val, sym_q};
    assign dec      = decode_sym(sym_full);
    assign emit_byte = {dec.nib, lo_nib_q};
    assign sop_hit  = (state_q == RX_HUNT) && !line_static && bit_stb &&
                      (kcode_hits(win_nxt) >= 3'd3);

    always_comb begin
        emit    = 1'b0;
        fin     = 1'b0;
        fin_err = 1'b0;
        if (state_q == RX_DATA) begin
            if (bit_stb && bcnt_q == 3'd4) begin
                case (dec.kind)
                    SYM_DATA: emit = nib_half_q;
                    SYM_EOP: begin
                        fin     = 1'b1;
                        fin_err = (crc_q != CRC_RESIDUE);
                    end
                    default: begin
                        fin     = 1'b1;
                        fin_err = 1'b1;
                    end
                endcase
            end else if (line_static) begin
                fin     = 1'b1;
                fin_err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= RX_HUNT;
            win_q      <= '0;
            sym_q      <= '0;
            lo_nib_q   <= '0;
            bcnt_q     <= '0;
            nib_half_q <= 1'b0;
            crc_q      <= '1;
            cnt_q      <= '0;
            pay_size   <= '0;
        end else begin
            case (state_q)
                RX_HUNT: begin
                    if (line_static) win_q <= '0;
                    else if (bit_stb) win_q <= win_nxt[19:1];
                    if (sop_hit) begin
                        state_q    <= RX_DATA;
                        bcnt_q     <= '0;
                        nib_half_q <= 1'b0;
                        crc_q      <= '1;
                        cnt_q      <= '0;
                    end
                end
                RX_DATA: begin
                    if (bit_stb) begin
                        sym_q  <= sym_full[4:1];
                        bcnt_q <= (bcnt_q == 3'd4) ? 3'd0 : bcnt_q + 3'd1;
                        if (bcnt_q == 3'd4 && dec.kind == SYM_DATA) begin
                            if (nib_half_q) begin
                                nib_half_q <= 1'b0;
                                crc_q      <= crc32_byte(crc_q, emit_byte);
                                cnt_q      <= cnt_q + SIZE_W'(1);
                            end else begin
                                lo_nib_q   <= dec.nib;
                                nib_half_q <= 1'b1;
                            end
                        end
                    end
                    if (fin) begin
                        state_q  <= RX_DRAIN;
                        pay_size <= cnt_q;
                    end
                end
                default: begin
                    if (line_static) begin
                        state_q <= RX_HUNT;
                        win_q   <= '0;
                    end
                end
            endcase
        end
    end

    // Byte stream and sticky flags
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data  <= '0;
            rx_valid <= 1'b0;
            ord_det  <= 1'b0;
            msg_end  <= 1'b0;
            rx_err   <= 1'b0;
            rx_ovr   <= 1'b0;
        end else begin
            if (rx_valid && rx_ready) rx_valid <= 1'b0;
            if (emit && (!rx_valid || rx_ready)) begin
                rx_data  <= emit_byte;
                rx_valid <= 1'b1;
            end
            if (emit && rx_valid && !rx_ready) rx_ovr <= 1'b1;
            else if (clr_ovr)                  rx_ovr <= 1'b0;
            if (sop_hit)               ord_det <= 1'b1;
            else if (fin || clr_ord)   ord_det <= 1'b0;
            if (fin)          msg_end <= 1'b1;
            else if (clr_end) msg_end <= 1'b0;
            if (fin && fin_err) rx_err <= 1'b1;
            else if (clr_end)   rx_err <= 1'b0;
        end
    end
endmodule

// File: rtl/pd_bmc_rx_chk.sv
module pd_bmc_rx_chk #(
    parameter int SIZE_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_ready,
    input logic [7:0]        rx_data,
    input logic              rx_valid,
    input logic              ord_det,
    input logic              msg_end,
    input logic              rx_err,
    input logic              rx_ovr,
    input logic [SIZE_W-1:0] pay_size
);
    assert_hold_byte_R4: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

    assert_ovr_cause_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_ovr) |-> $past(rx_valid && !rx_ready));

    assert_ord_drop_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(msg_end) |-> !ord_det);

    // Covers the error paths of R5, R7 and R8: an error never appears without message end
    assert_err_with_end_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_err) |-> msg_end);

    assert_size_at_end_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(pay_size) |-> msg_end);
endmodule

bind pd_bmc_rx pd_bmc_rx_chk #(.SIZE_W(SIZE_W)) u_chk (
    .clk(clk), .rst(rst), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_valid(rx_valid), .ord_det(ord_det), .msg_end(msg_end),
    .rx_err(rx_err), .rx_ovr(rx_ovr), .pay_size(pay_size)
);

// File: tb/pd_bmc_rx_tb.sv
`timescale 1ns/1ps
module pd_bmc_rx_tb;
    localparam int H = 8;  // clocks per half bit, matches the default parameter

    // {len[27:24], first[23:16], step[15:8], kcode spoil mask[7:4], bad crc[0]}
    localparam logic [27:0] VEC [4] = '{
        28'h2A51100,
        28'h3003C10,
        28'h1FF0001,
        28'h45A0740
    };

    logic clk = 1'b0, rst = 1'b1, cc = 1'b0, rdy = 1'b1;
    logic clr_ord = 1'b0, clr_end = 1'b0, clr_ovr = 1'b0;
    logic [7:0] rx_data;
    logic rx_valid, ord_det, msg_end, rx_err, rx_ovr;
    logic [9:0] pay_size;

    int n_cmp = 0, n_bad = 0, ngot = 0;
    logic [7:0] got   [0:15];
    logic [7:0] exp_b [0:15];

    always #2.5 clk = ~clk;

    pd_bmc_rx u_dut (
        .clk(clk), .rst(rst), .cc_line(cc), .rx_ready(rdy),
        .clr_ord(clr_ord), .clr_end(clr_end), .clr_ovr(clr_ovr),
        .rx_data(rx_data), .rx_valid(rx_valid), .ord_det(ord_det),
        .msg_end(msg_end), .rx_err(rx_err), .rx_ovr(rx_ovr), .pay_size(pay_size)
    );

    always @(posedge clk) begin
        if (!rst && rx_valid && rdy) begin
            if (ngot < 16) got[ngot] = rx_data;
            ngot = ngot + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] enc4(input logic [3:0] n);
        case (n)
            4'h0: return 5'b11110; 4'h1: return 5'b01001; 4'h2: return 5'b10100; 4'h3: return 5'b10101;
            4'h4: return 5'b01010; 4'h5: return 5'b01011; 4'h6: return 5'b01110; 4'h7: return 5'b01111;
            4'h8: return 5'b10010; 4'h9: return 5'b10011; 4'hA: return 5'b10110; 4'hB: return 5'b10111;
            4'hC: return 5'b11010; 4'hD: return 5'b11011; 4'hE: return 5'b11100; default: return 5'b11101;
        endcase
    endfunction

    function automatic logic [31:0] crc_b(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) r = (r[0] ^ b[i]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
        return r;
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        cc = ~cc; wait_clk(H);
        if (b) cc = ~cc;
        wait_clk(H);
    endtask

    task automatic send_sym(input logic [4:0] s);
        for (int i = 0; i < 5; i++) send_bit(s[i]);
    endtask

    task automatic send_byte(input logic [7:0] b);
        send_sym(enc4(b[3:0]));
        send_sym(enc4(b[7:4]));
    endtask

    task automatic send_head(input logic [3:0] spoil);
        for (int i = 0; i < 64; i++) send_bit(i[0]);
        for (int k = 0; k < 4; k++) send_sym(spoil[k] ? 5'b00111 : (k == 3 ? 5'b10001 : 5'b11000));
    endtask

    task automatic send_tail();
        cc = ~cc;
        wait_clk(130);
    endtask

    task automatic pulse_clr_end();
        clr_end = 1'b1; wait_clk(1); clr_end = 1'b0; wait_clk(1);
    endtask

    task automatic send_packet(input int len, input logic [7:0] first, input logic [7:0] step,
                               input logic [3:0] spoil, input logic bad);
        logic [31:0] c, fcs;
        logic [7:0]  b;
        c = 32'hFFFFFFFF;
        send_head(spoil);
        for (int i = 0; i < len; i++) begin
            b = first + 8'(i) * step;
            exp_b[i] = b;
            c = crc_b(c, b);
            send_byte(b);
        end
        fcs = ~c;
        if (bad) fcs = fcs ^ 32'h1;
        for (int k = 0; k < 4; k++) begin
            exp_b[len + k] = fcs[8*k +: 8];
            send_byte(fcs[8*k +: 8]);
        end
        send_sym(5'b01101);
        send_tail();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);
        // R1 reset state
        chk("R1 rx_valid", rx_valid, 0);
        chk("R1 flags", {ord_det, msg_end, rx_err, rx_ovr}, 0);
        chk("R1 pay_size", pay_size, 0);
        wait_clk(80);

        // Table of packets: R2 R3 R4 R5 R6 R10 R11
        for (int v = 0; v < 4; v++) begin
            int len;
            len  = int'(VEC[v][27:24]);
            ngot = 0;
            send_packet(len, VEC[v][23:16], VEC[v][15:8], VEC[v][7:4], VEC[v][0]);
            chk("R4 byte count", ngot, len + 4);
            for (int i = 0; i < len + 4; i++) chk("R4 R2 byte value", got[i], exp_b[i]);
            chk("R6 pay_size", pay_size, len + 4);
            chk("R5 msg_end", msg_end, 1);
            chk("R5 rx_err", rx_err, VEC[v][0]);
            chk("R11 ord_det cleared", ord_det, 0);
            pulse_clr_end();
            chk("R10 clr_end", {msg_end, rx_err}, 0);
        end

        // R3 ord_det mid message, R10 clr_ord, R7 truncation
        ngot = 0;
        send_head(4'b0000);
        send_byte(8'h81);
        chk("R3 ord_det set", ord_det, 1);
        clr_ord = 1'b1; wait_clk(1); clr_ord = 1'b0; wait_clk(1);
        chk("R10 clr_ord", ord_det, 0);
        send_byte(8'h7E);
        send_tail();
        chk("R7 truncated err", {msg_end, rx_err}, 2'b11);
        chk("R7 pay_size", pay_size, 2);
        chk("R7 bytes", ngot, 2);
        pulse_clr_end();

        // R8 invalid symbol
        ngot = 0;
        send_head(4'b0000);
        send_byte(8'h33);
        send_sym(5'b00000);
        send_tail();
        chk("R8 bad symbol err", {msg_end, rx_err}, 2'b11);
        chk("R8 pay_size", pay_size, 1);
        pulse_clr_end();

        // R9 overrun with a stalled consumer
        rdy  = 1'b0;
        ngot = 0;
        send_packet(2, 8'h12, 8'h22, 4'b0000, 1'b0);
        chk("R9 rx_ovr", rx_ovr, 1);
        chk("R9 held valid", rx_valid, 1);
        chk("R9 held byte", rx_data, 8'h12);
        chk("R9 crc ok", rx_err, 0);
        chk("R6 pay_size ovr", pay_size, 6);
        rdy = 1'b1;
        wait_clk(2);
        chk("R9 drained", rx_valid, 0);
        chk("R9 one byte taken", ngot, 1);
        clr_ovr = 1'b1; wait_clk(1); clr_ovr = 1'b0; wait_clk(1);
        chk("R10 clr_ovr", rx_ovr, 0);
        pulse_clr_end();

        // R12 two spoiled K-codes
        ngot = 0;
        send_head(4'b0011);
        send_sym(5'b01101);
        send_tail();
        chk("R12 no ord_det", ord_det, 0);
        chk("R12 no msg_end", msg_end, 0);
        chk("R12 no bytes", ngot, 0);

        summary();
        $finish;
    end
endmodule